// File: doc/BRIEF.md
# Radix-4 On-the-Fly Root Converter and Multiple Former

This block sits beside a radix-4 digit-recurrence divide or square-root datapath. Each iteration the selection logic produces one signed digit in the range -2..+2; the block folds that digit into a running result without any carry-propagate addition. It does this by holding two estimates: the result itself, and the result minus one unit of the latest digit position. The decremented estimate is stored as its bitwise complement, cleared below the current digit position. Every update then only picks one of the two estimates and appends a two-bit field at the position named by the iteration index.

In square-root mode the block also returns, in the same cycle as the digit, the negated multiple that the remainder update must add. This is 2·d·Q + d²·w, where Q is the result before the digit and w is the digit's weight. It comes out as a one's-complement word plus a carry-in bit. For a positive digit the word is built from the positive estimate; for a negative digit it is built from the complemented estimate. In both cases it takes one shift, one OR with a single weighted bit and one inversion. In divide mode the remainder multiple comes from the divisor, outside this block, and the output stays zero.

Results are fixed point: with NDIG digits, the value 1.0 is 4^NDIG, and digit k (k = 1..NDIG) has weight 4^(NDIG-k). All values are held modulo 2^W with W = 2·NDIG+4.

Top module: `otf_root_conv`

## Requirements
- R1: After reset, q_pos is 0, q_dec is 2^W − 4^NDIG (that is, −1.0), neg_mult is 0 and mult_cin is 0.
- R2: When start is high at a clock edge, the block loads an initial state in the next cycle. With root_mode=1, q_pos is 4^NDIG and q_dec is 0; with root_mode=0, q_pos is 0 and q_dec is 2^W − 4^NDIG. The mode is held until the next start. Start takes priority over step in the same cycle.
- R3: When a step is accepted with digit d at index k, one cycle later q_pos equals the previous q_pos + d·4^(NDIG−k), modulo 2^W.
- R4: q_dec always equals q_pos − 4^(NDIG−k) modulo 2^W, where k is the index of the last accepted step, or 0 since the last start or reset.
- R5: With the default signed encoding, digit is 3-bit two's complement: 000=0, 001=+1, 010=+2, 111=−1, 110=−2. Codes 011, 100 and 101 are illegal. A step with an illegal code, or with idx of 0 or above NDIG, is ignored and leaves q_pos and q_dec unchanged. In the one-hot variant, bit j stands for digit j−2.
- R6: In root mode, during an accepted step with a nonzero digit d at index k, mult_cin is 1 and neg_mult + mult_cin equals −(2·d·Q + d²·4^(NDIG−k)) modulo 2^W. Q is q_pos before the step, and both outputs are valid in the same cycle.
- R7: In all other cases neg_mult and mult_cin are 0: divide mode, a zero digit, no step, an ignored step, or start high.
- R8: q_pos has no bits set below the position of the last accepted digit, 2·(NDIG−k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new operation; loads the initial estimates |
| root_mode | input | 1 | Mode taken at start: 1 square root, 0 divide |
| step | input | 1 | A digit is presented this cycle |
| digit | input | 3 (5 one-hot) | Result digit code |
| idx | input | $clog2(NDIG+2) | Iteration index of the digit, 1..NDIG |
| q_pos | output | W | Current result estimate |
| q_dec | output | W | Result minus one unit of the last digit position |
| neg_mult | output | W | One's-complement negated square-root multiple |
| mult_cin | output | 1 | Carry-in that completes neg_mult to two's complement |

## Verification
The bench goes after negative digits taken from the decremented estimate. If the wrong base is chosen, or the wrong append value is used (d+4 versus d−1), q_pos or q_dec drifts from the exact signed-digit sum. It runs long strings of −2 and +2 in both modes, where a wrong trailing-bit mask on the complemented estimate leaves stray ones and corrupts the multiple for negative digits. It also drives illegal codes, out-of-range indices and start colliding with step. A block that accepted any of these would change the estimates or produce a nonzero multiple in the cycle where it must stay silent.

// File: rtl/otf_root_pkg.sv
package otf_root_pkg;

  // Decoded digit: ok marks a legal code, neg the sign, mag the magnitude 0..2.
  typedef struct packed {
    logic       ok;
    logic       neg;
    logic [1:0] mag;
  } otf_digit_t;

  // Signed 3-bit code: two's complement, values -2..+2 legal.
  function automatic otf_digit_t decode_signed3(input logic [2:0] c);
    otf_digit_t r;
    r = '{ok: 1'b1, neg: 1'b0, mag: 2'd0};
    case (c)
      3'b000: r.mag = 2'd0;
      3'b001: r.mag = 2'd1;
      3'b010: r.mag = 2'd2;
      3'b111: begin r.neg = 1'b1; r.mag = 2'd1; end
      3'b110: begin r.neg = 1'b1; r.mag = 2'd2; end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  // One-hot code: bit j means digit j-2.
  function automatic otf_digit_t decode_onehot5(input logic [4:0] c);
    otf_digit_t r;
    r = '{ok: $onehot(c), neg: 1'b0, mag: 2'd0};
    if (c[0]) begin r.neg = 1'b1; r.mag = 2'd2; end
    if (c[1]) begin r.neg = 1'b1; r.mag = 2'd1; end
    if (c[3]) r.mag = 2'd1;
    if (c[4]) r.mag = 2'd2;
    return r;
  endfunction

  function automatic logic is_zero(input otf_digit_t d);
    return d.mag == 2'd0;
  endfunction

  function automatic logic is_positive(input otf_digit_t d);
    return !d.neg && d.mag != 2'd0;
  endfunction

  // Field appended to the chosen base for the new positive estimate:
  // d for d >= 0, d+4 for d < 0.
  function automatic logic [1:0] field_plus(input otf_digit_t d);
    logic [1:0] f;
    if (!d.neg) f = d.mag;
    else if (d.mag == 2'd1) f = 2'd3;
    else f = 2'd2;
    return f;
  endfunction

  // Field appended for the new decremented estimate:
  // d-1 for d > 0, d+3 for d <= 0.
  function automatic logic [1:0] field_minus(input otf_digit_t d);
    logic [1:0] f;
    if (is_positive(d)) f = d.mag - 2'd1;
    else if (d.mag == 2'd0) f = 2'd3;
    else if (d.mag == 2'd1) f = 2'd2;
    else f = 2'd1;
    return f;
  endfunction

endpackage

// File: rtl/otf_digit_dec.sv
module otf_digit_dec
  import otf_root_pkg::*;
#(
  parameter bit DIGIT_ONEHOT = 1'b0,
  localparam int DW = DIGIT_ONEHOT ? 5 : 3
) (
  input  logic [DW-1:0] code,
  output otf_digit_t    dig
);

  generate
    if (DIGIT_ONEHOT) begin : g_onehot
      assign dig = decode_onehot5(code);
    end else begin : g_signed
      assign dig = decode_signed3(code);
    end
  endgenerate

endmodule

// File: rtl/otf_estimates.sv
module otf_estimates
  import otf_root_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W  = 2 * NDIG + 4,
  localparam int PW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          root_mode,
  input  logic          acc,
  input  otf_digit_t    dig,
  input  logic [PW-1:0] pos_k,
  output logic [W-1:0]  qp,
  output logic [W-1:0]  qn,
  output logic [W-1:0]  qm,
  output logic [PW-1:0] pos_q,
  output logic          mode_q
);

  localparam logic [W-1:0]  ALL_ONES = {W{1'b1}};
  localparam logic [PW-1:0] TOP_POS  = PW'(2 * NDIG);
  localparam logic [W-1:0]  ONE_VAL  = W'(1) << (2 * NDIG);
  localparam logic [W-1:0]  QN_ROOT0 = ALL_ONES << (2 * NDIG);

  function automatic logic [W-1:0] keep_above(input logic [W-1:0] v,
                                              input logic [PW-1:0] p);
    return v & (ALL_ONES << p);
  endfunction

  function automatic logic [W-1:0] place(input logic [1:0] f,
                                         input logic [PW-1:0] p);
    return W'(f) << p;
  endfunction

  logic [W-1:0] base_plus, base_minus;
  logic [W-1:0] qp_next, qm_next, qn_next;
  logic         take_pos_base, take_pos_base_m;

  // Decremented estimate recovered from its stored complement.
  assign qm = ~qn & (ALL_ONES << pos_q);

  assign take_pos_base   = !dig.neg || is_zero(dig);
  assign take_pos_base_m = is_positive(dig);
  assign base_plus       = take_pos_base   ? qp : qm;
  assign base_minus      = take_pos_base_m ? qp : qm;

  assign qp_next = base_plus  | place(field_plus(dig),  pos_k);
  assign qm_next = base_minus | place(field_minus(dig), pos_k);
  assign qn_next = keep_above(~qm_next, pos_k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qp     <= '0;
      qn     <= '0;
      pos_q  <= TOP_POS;
      mode_q <= 1'b0;
    end else if (start) begin
      mode_q <= root_mode;
      qp     <= root_mode ? ONE_VAL  : '0;
      qn     <= root_mode ? QN_ROOT0 : '0;
      pos_q  <= TOP_POS;
    end else if (acc) begin
      qp    <= qp_next;
      qn    <= qn_next;
      pos_q <= pos_k;
    end
  end

endmodule

// File: rtl/otf_multiple.sv
module otf_multiple
  import otf_root_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W  = 2 * NDIG + 4,
  localparam int PW = $clog2(W + 1)
) (
  input  logic          active,
  input  otf_digit_t    dig,
  input  logic [W-1:0]  qp,
  input  logic [W-1:0]  qn,
  input  logic [PW-1:0] pos_k,
  output logic [W-1:0]  neg_mult,
  output logic          mult_cin
);

  logic [W-1:0]  src;
  logic [W-1:0]  shifted;
  logic [W-1:0]  weight_bit;
  logic [PW-1:0] bit_pos;
  logic          fire;

  // Positive digits use the positive estimate, negative ones the complement.
  assign src        = dig.neg ? qn : qp;
  assign shifted    = (dig.mag == 2'd2) ? (src << 2) : (src << 1);
  assign bit_pos    = (dig.mag == 2'd2) ? (pos_k + PW'(2)) : pos_k;
  assign weight_bit = W'(1) << bit_pos;
  assign fire       = active && dig.ok && !is_zero(dig);

  assign neg_mult = fire ? ~(shifted | weight_bit) : '0;
  assign mult_cin = fire;

endmodule

// File: rtl/otf_root_conv.sv
module otf_root_conv
  import otf_root_pkg::*;
#(
  parameter int NDIG = 8,
  parameter bit DIGIT_ONEHOT = 1'b0,
  localparam int W  = 2 * NDIG + 4,
  localparam int PW = $clog2(W + 1),
  localparam int IW = $clog2(NDIG + 2),
  localparam int DW = DIGIT_ONEHOT ? 5 : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          root_mode,
  input  logic          step,
  input  logic [DW-1:0] digit,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  q_pos,
  output logic [W-1:0]  q_dec,
  output logic [W-1:0]  neg_mult,
  output logic          mult_cin
);

  otf_digit_t    dig;
  logic          idx_ok;
  logic          acc;
  logic [PW-1:0] pos_k;
  logic [W-1:0]  qp, qn, qm;
  logic [PW-1:0] pos_q;
  logic          mode_q;

  otf_digit_dec #(.DIGIT_ONEHOT(DIGIT_ONEHOT)) u_dec (
    .code (digit),
    .dig  (dig)
  );

  assign idx_ok = (idx != '0) && (int'(idx) <= NDIG);
  assign acc    = step && !start && idx_ok && dig.ok;
  assign pos_k  = PW'(2 * NDIG) - PW'({idx, 1'b0});

  otf_estimates #(.NDIG(NDIG)) u_est (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .root_mode (root_mode),
    .acc       (acc),
    .dig       (dig),
    .pos_k     (pos_k),
    .qp        (qp),
    .qn        (qn),
    .qm        (qm),
    .pos_q     (pos_q),
    .mode_q    (mode_q)
  );

  otf_multiple #(.NDIG(NDIG)) u_mul (
    .active   (acc && mode_q),
    .dig      (dig),
    .qp       (qp),
    .qn       (qn),
    .pos_k    (pos_k),
    .neg_mult (neg_mult),
    .mult_cin (mult_cin)
  );

  assign q_pos = qp;
  assign q_dec = qm;

endmodule

// File: rtl/otf_root_conv_chk.sv
module otf_root_conv_chk #(
  parameter int NDIG = 8,
  localparam int W  = 2 * NDIG + 4,
  localparam int PW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          root_mode,
  input logic          step,
  input logic          acc,
  input logic          mode_q,
  input logic [PW-1:0] pos_q,
  input logic [W-1:0]  q_pos,
  input logic [W-1:0]  q_dec,
  input logic [W-1:0]  neg_mult,
  input logic          mult_cin
);

  localparam logic [W-1:0] ONE_VAL = W'(1) << (2 * NDIG);

  // R2: start loads the mode-dependent initial estimate
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (q_pos == ($past(root_mode) ? ONE_VAL : '0)) && (mode_q == $past(root_mode)));

  // R4: the companion sits exactly one unit of the last position below
  p_ulp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pos - q_dec) == (W'(1) << pos_q));

  // R5: a step that was not accepted changes nothing
  p_ignored_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !acc) |=> $stable(q_pos) && $stable(q_dec));

  // R6: carry-in only appears for an accepted root-mode step
  p_cin_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mult_cin |-> (acc && mode_q));

  // R7: no multiple outside an accepted root-mode step
  p_quiet_mult_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc || !mode_q) |-> (neg_mult == '0 && !mult_cin));

  // R8: nothing below the last appended digit position
  p_low_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pos & ~({W{1'b1}} << pos_q)) == '0);

endmodule

bind otf_root_conv otf_root_conv_chk #(.NDIG(NDIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .root_mode (root_mode),
  .step      (step),
  .acc       (acc),
  .mode_q    (mode_q),
  .pos_q     (pos_q),
  .q_pos     (q_pos),
  .q_dec     (q_dec),
  .neg_mult  (neg_mult),
  .mult_cin  (mult_cin)
);

// File: tb/otf_root_conv_test.sv
module otf_root_conv_test;

  localparam int NDIG = 8;
  localparam int W    = 2 * NDIG + 4;
  localparam int IW   = $clog2(NDIG + 2);
  localparam longint MODV = longint'(1) << W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          root_mode = 1'b0;
  logic          step = 1'b0;
  logic [2:0]    digit = 3'b000;
  logic [IW-1:0] idx = '0;
  logic [W-1:0]  q_pos, q_dec, neg_mult;
  logic          mult_cin;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference state: exact value, last index, mode.
  longint mq = 0;
  int     mk = 0;
  bit     mroot = 1'b0;

  always #5 clk = ~clk;

  otf_root_conv #(.NDIG(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .root_mode(root_mode),
    .step(step), .digit(digit), .idx(idx),
    .q_pos(q_pos), .q_dec(q_dec), .neg_mult(neg_mult), .mult_cin(mult_cin)
  );

  function automatic longint wrap(input longint x);
    return ((x % MODV) + MODV) % MODV;
  endfunction

  function automatic longint unit_of(input int k);
    return longint'(1) << (2 * (NDIG - k));
  endfunction

  // Legal codes and their values, written from the requirement table.
  function automatic bit code_legal(input logic [2:0] c);
    return c == 3'b000 || c == 3'b001 || c == 3'b010 || c == 3'b111 || c == 3'b110;
  endfunction

  function automatic int code_value(input logic [2:0] c);
    return int'($signed(c));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(longint'(q_pos) == wrap(mq), {req, " q_pos"}, longint'(q_pos), wrap(mq));
    check(longint'(q_dec) == wrap(mq - unit_of(mk)), "R4 q_dec", longint'(q_dec),
          wrap(mq - unit_of(mk)));
  endtask

  // One clock: drive at negedge, check combinational multiple, then registers.
  task automatic cycle(input bit st, input bit rt, input bit sp,
                       input logic [2:0] code, input int ix, input string req);
    bit     accept;
    int     d;
    longint expm;
    @(negedge clk);
    start = st; root_mode = rt; step = sp; digit = code; idx = IW'(ix);
    #1;
    accept = sp && !st && ix >= 1 && ix <= NDIG && code_legal(code);
    d = code_value(code);
    if (accept && mroot && d != 0) begin
      expm = wrap(-(2 * d * mq + d * d * unit_of(ix)));
      check(wrap(longint'(neg_mult) + longint'(mult_cin)) == expm,
            "R6 multiple", wrap(longint'(neg_mult) + longint'(mult_cin)), expm);
      check(mult_cin == 1'b1, "R6 carry-in", longint'(mult_cin), 1);
    end else begin
      check(neg_mult == '0 && !mult_cin, "R7 quiet multiple",
            longint'(neg_mult), 0);
    end
    @(posedge clk);
    if (st) begin
      mroot = rt; mk = 0;
      mq = rt ? unit_of(0) : 0;
    end else if (accept) begin
      mq = mq + d * unit_of(ix);
      mk = ix;
    end
    #1;
    check_regs(req);
    check((longint'(q_pos) & (unit_of(mk) - 1)) == 0, "R8 low bits",
          longint'(q_pos) & (unit_of(mk) - 1), 0);
  endtask

  function automatic logic [2:0] rand_code();
    logic [2:0] t [5] = '{3'b000, 3'b001, 3'b010, 3'b111, 3'b110};
    return t[$urandom_range(0, 4)];
  endfunction

  task automatic run(input bit rt, input int kind);
    cycle(1'b1, rt, 1'b0, 3'b000, 0, "R2 start");
    for (int k = 1; k <= NDIG; k++) begin
      logic [2:0] c;
      case (kind)
        1: c = 3'b110;
        2: c = 3'b010;
        3: c = 3'b111;
        default: c = rand_code();
      endcase
      cycle(1'b0, rt, 1'b1, c, k, "R3 step");
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(q_pos == '0, "R1 q_pos", longint'(q_pos), 0);
    check(longint'(q_dec) == wrap(-unit_of(0)), "R1 q_dec", longint'(q_dec), wrap(-unit_of(0)));
    check(neg_mult == '0 && !mult_cin, "R1 multiple", longint'(neg_mult), 0);
    rst_n = 1'b1;

    // R2/R3: mode loads and random digit strings in both modes
    for (int r = 0; r < 30; r++) run(r[0], 0);
    // Extremes: all -2, all +2, all -1 in both modes
    for (int kind = 1; kind <= 3; kind++) begin
      run(1'b1, kind);
      run(1'b0, kind);
    end

    // R5: illegal codes and out-of-range index mid-run; then resume
    cycle(1'b1, 1'b1, 1'b0, 3'b000, 0, "R2 start");
    cycle(1'b0, 1'b1, 1'b1, 3'b111, 1, "R3 step");
    cycle(1'b0, 1'b1, 1'b1, 3'b011, 2, "R5 illegal 011");
    cycle(1'b0, 1'b1, 1'b1, 3'b100, 2, "R5 illegal 100");
    cycle(1'b0, 1'b1, 1'b1, 3'b101, 2, "R5 illegal 101");
    cycle(1'b0, 1'b1, 1'b1, 3'b001, 0, "R5 idx zero");
    cycle(1'b0, 1'b1, 1'b1, 3'b010, NDIG + 1, "R5 idx high");
    cycle(1'b0, 1'b1, 1'b0, 3'b010, 2, "R7 no step");
    cycle(1'b0, 1'b1, 1'b1, 3'b000, 2, "R7 zero digit");
    cycle(1'b0, 1'b1, 1'b1, 3'b110, 3, "R3 step after ignores");

    // R2: start wins over a simultaneous step, divide mode multiple quiet
    cycle(1'b1, 1'b0, 1'b1, 3'b010, 1, "R2 start over step");
    cycle(1'b0, 1'b0, 1'b1, 3'b010, 1, "R7 divide step");
    cycle(1'b1, 1'b1, 1'b1, 3'b110, 1, "R2 start over step root");
    cycle(1'b0, 1'b0, 1'b1, 3'b110, 1, "R3 root held after start");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule